// File: doc/BRIEF.md
# I2C Slave Address Decoder

This block decides whether an I2C slave claims the transfer that follows a START or a repeated START. It is fed the bytes that the bit-level receiver has already shifted in, one strobe per byte, together with START and STOP strobes. It compares the address byte or bytes against two programmable own addresses and against the general-call address. For each byte that needs one, it returns an acknowledge decision, and it reports which target was selected and in which direction the transfer runs.

Each own address has its own enable and can be switched to 10-bit addressing on its own. General calls are acknowledged under one of two enables. Which enable applies depends on whether the current master is the local master, reaching this slave over the shared bus internally, or an external master. Once an address has matched, each write data byte is acknowledged or refused according to a per-target write-acknowledge enable. The control fields are expected to change only while no transfer is selected.

Top module: `i2c_addr_decoder`

## Requirements
- R1: After reset, match_o is 0 (no target), and read_o, ack_valid_o and ack_o are all low.
- R2: In 7-bit mode, an address byte whose bits [7:3] are not 11110, and which is neither 0x00 nor 0x01, matches an enabled 7-bit own address when byte bits [7:1] equal address bits [6:0]. A match is acknowledged and sets match_o to 1 for own address 0 or to 2 for own address 1, and read_o to byte bit 0.
- R3: An own address that is disabled, or that is in the other addressing mode, never matches, and an address byte that matches nothing is refused (ack_o low).
- R4: When both own addresses match the same byte, own address 0 wins.
- R5: A 10-bit write takes two bytes. The first is a header 11110 a9 a8 0, acknowledged when any enabled 10-bit own address has those upper bits. The second byte must equal address bits [7:0]; if it does, the byte is acknowledged and the target is selected for write, and if not, the byte is refused.
- R6: After a 10-bit write has selected an address, a repeated START followed by header 11110 a9 a8 1 for that same address is acknowledged and selects it for read. The same header with no such earlier selection since the last STOP is refused.
- R7: Byte 0x00 is a general call, which sets match_o to 3 with read_o low. It is acknowledged when loopback_i is high and gc_local_en_i is set, or when loopback_i is low and gc_ext_en_i is set.
- R8: Byte 0x01, a general call asking for a read, is always refused and selects nothing.
- R9: While a write is selected, each data byte is acknowledged per own_wr_ack_i[0] for own address 0, per own_wr_ack_i[1] for own address 1, and per gc_data_ack_i for a general call.
- R10: ack_valid_o pulses for exactly one cycle, one clock after the strobe of an address byte or of a write data byte. Bytes that arrive in the read phase, after a refused address, or with no START before them produce no pulse.
- R11: START clears the selection and direction and makes the next byte an address byte. STOP clears the selection, the direction and the remembered 10-bit selection, and returns to idle. STOP takes priority over START, and START over a byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START strobe |
| stop_i | input | 1 | STOP strobe |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte, MSB first as on the bus |
| loopback_i | input | 1 | Current master is the local master |
| own_en_i | input | 2 | Enable per own address |
| own_ten_i | input | 2 | 10-bit mode per own address |
| own_addr_i | input | 2x10 | Own addresses, 7-bit ones in bits [6:0] |
| own_wr_ack_i | input | 2 | Acknowledge write data per own address |
| gc_local_en_i | input | 1 | Acknowledge general call from the local master |
| gc_ext_en_i | input | 1 | Acknowledge general call from external masters |
| gc_data_ack_i | input | 1 | Acknowledge general-call data bytes |
| match_o | output | 2 | 0 none, 1 own address 0, 2 own address 1, 3 general call |
| read_o | output | 1 | Selected transfer is a read |
| ack_valid_o | output | 1 | Acknowledge decision valid (one-cycle pulse) |
| ack_o | output | 1 | 1 means ACK, 0 means NACK |

## Verification
Every result comes from a single register stage. The ack_valid_o pulse, ack_o, match_o and read_o that follow a byte strobe are therefore due on the first clock edge after that strobe. The clearing done by START and STOP is due on the first edge after those strobes as well. The bench drives each strobe for one cycle at a falling edge, and compares all four outputs at the next falling edge, which is one full edge after the strobe was captured, against values its own transfer model predicts. Directed sequences cover priority, repeated-START reselection, STOP clearing the 10-bit memory, and simultaneous strobes. A seeded random run then mixes configurations and transfer shapes.

// File: rtl/i2c_adec_pkg.sv
package i2c_adec_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam int N_OWN  = 2;
    localparam int HDR_W  = 5;
    localparam int SEV_W  = 7;
    localparam logic [HDR_W-1:0] TEN_HDR = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_WR  = 8'h00;
    localparam logic [BYTE_W-1:0] GC_RD  = 8'h01;

    typedef enum logic [1:0] {
        MT_NONE  = 2'd0,
        MT_OWN0  = 2'd1,
        MT_OWN1  = 2'd2,
        MT_GCALL = 2'd3
    } match_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_LOW,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e           phase;
        match_e           match;
        logic             rd;
        logic             ack_vld;
        logic             ack;
        logic [N_OWN-1:0] cand;
        logic [N_OWN-1:0] sel;
    } dec_state_t;

    // lowest index wins
    function automatic match_e first_hit(input logic [N_OWN-1:0] hits);
        match_e m;
        m = MT_NONE;
        for (int i = N_OWN - 1; i >= 0; i--) begin
            if (hits[i]) m = match_e'(i + 1);
        end
        return m;
    endfunction

    function automatic logic [N_OWN-1:0] hit_onehot(input match_e m);
        logic [N_OWN-1:0] v;
        v = '0;
        for (int i = 0; i < N_OWN; i++) begin
            if (m == match_e'(i + 1)) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/i2c_adec_own_cmp.sv
module i2c_adec_own_cmp
    import i2c_adec_pkg::*;
(
    input  logic              en_i,
    input  logic              ten_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hit7_o,
    output logic              hi10_o,
    output logic              lo10_o
);
    logic is_hdr;

    always_comb begin
        is_hdr = (byte_i[BYTE_W-1 -: HDR_W] == TEN_HDR);
        hit7_o = en_i && !ten_i && !is_hdr
                 && (byte_i[BYTE_W-1:1] == addr_i[SEV_W-1:0]);
        hi10_o = en_i && ten_i && is_hdr
                 && (byte_i[2:1] == addr_i[ADDR_W-1:BYTE_W]);
        lo10_o = en_i && ten_i && (byte_i == addr_i[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c_adec_gcall.sv
module i2c_adec_gcall
    import i2c_adec_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              loopback_i,
    input  logic              local_en_i,
    input  logic              ext_en_i,
    output logic              gc_wr_o,
    output logic              gc_rd_o,
    output logic              gc_ack_o
);
    always_comb begin
        gc_wr_o  = (byte_i == GC_WR);
        gc_rd_o  = (byte_i == GC_RD);
        gc_ack_o = loopback_i ? local_en_i : ext_en_i;
    end
endmodule

// File: rtl/i2c_addr_decoder.sv
module i2c_addr_decoder
    import i2c_adec_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic                         stop_i,
    input  logic                         byte_valid_i,
    input  logic [7:0]                   byte_i,
    input  logic                         loopback_i,
    input  logic [1:0]                   own_en_i,
    input  logic [1:0]                   own_ten_i,
    input  logic [1:0][9:0]              own_addr_i,
    input  logic [1:0]                   own_wr_ack_i,
    input  logic                         gc_local_en_i,
    input  logic                         gc_ext_en_i,
    input  logic                         gc_data_ack_i,
    output logic [1:0]                   match_o,
    output logic                         read_o,
    output logic                         ack_valid_o,
    output logic                         ack_o
);
    localparam dec_state_t RST_STATE = '{
        phase: PH_IDLE, match: MT_NONE, rd: 1'b0, ack_vld: 1'b0,
        ack: 1'b0, cand: '0, sel: '0};

    logic [N_OWN-1:0] hit7, hi10, lo10;
    logic             gc_wr, gc_rd, gc_ack;
    dec_state_t       st_d, st_q;

    for (genvar g = 0; g < N_OWN; g++) begin : g_own
        i2c_adec_own_cmp u_cmp (
            .en_i   (own_en_i[g]),
            .ten_i  (own_ten_i[g]),
            .addr_i (own_addr_i[g]),
            .byte_i (byte_i),
            .hit7_o (hit7[g]),
            .hi10_o (hi10[g]),
            .lo10_o (lo10[g])
        );
    end

    i2c_adec_gcall u_gc (
        .byte_i     (byte_i),
        .loopback_i (loopback_i),
        .local_en_i (gc_local_en_i),
        .ext_en_i   (gc_ext_en_i),
        .gc_wr_o    (gc_wr),
        .gc_rd_o    (gc_rd),
        .gc_ack_o   (gc_ack)
    );

    always_comb begin
        logic [N_OWN-1:0] pick;
        logic             is_hdr;
        st_d         = st_q;
        st_d.ack_vld = 1'b0;
        st_d.ack     = 1'b0;
        pick         = '0;
        is_hdr       = (byte_i[BYTE_W-1 -: HDR_W] == TEN_HDR);
        if (stop_i) begin
            st_d = RST_STATE;
        end else if (start_i) begin
            st_d.phase = PH_ADDR;
            st_d.match = MT_NONE;
            st_d.rd    = 1'b0;
            st_d.cand  = '0;
        end else if (byte_valid_i) begin
            case (st_q.phase)
                PH_ADDR: begin
                    st_d.ack_vld = 1'b1;
                    if (gc_wr) begin
                        st_d.ack   = gc_ack;
                        st_d.match = gc_ack ? MT_GCALL : MT_NONE;
                        st_d.phase = gc_ack ? PH_WRITE : PH_SKIP;
                    end else if (gc_rd) begin
                        st_d.phase = PH_SKIP;
                    end else if (is_hdr && !byte_i[0]) begin
                        st_d.cand  = hi10;
                        st_d.sel   = '0;
                        st_d.ack   = |hi10;
                        st_d.phase = (|hi10) ? PH_LOW : PH_SKIP;
                    end else if (is_hdr) begin
                        pick = hi10 & st_q.sel;
                        if (|pick) begin
                            st_d.ack   = 1'b1;
                            st_d.match = first_hit(pick);
                            st_d.rd    = 1'b1;
                            st_d.phase = PH_READ;
                        end else begin
                            st_d.phase = PH_SKIP;
                        end
                    end else if (|hit7) begin
                        st_d.ack   = 1'b1;
                        st_d.match = first_hit(hit7);
                        st_d.rd    = byte_i[0];
                        st_d.phase = byte_i[0] ? PH_READ : PH_WRITE;
                    end else begin
                        st_d.phase = PH_SKIP;
                    end
                end
                PH_LOW: begin
                    st_d.ack_vld = 1'b1;
                    pick         = lo10 & st_q.cand;
                    st_d.cand    = '0;
                    if (|pick) begin
                        st_d.ack   = 1'b1;
                        st_d.match = first_hit(pick);
                        st_d.sel   = hit_onehot(first_hit(pick));
                        st_d.phase = PH_WRITE;
                    end else begin
                        st_d.phase = PH_SKIP;
                    end
                end
                PH_WRITE: begin
                    st_d.ack_vld = 1'b1;
                    case (st_q.match)
                        MT_OWN0:  st_d.ack = own_wr_ack_i[0];
                        MT_OWN1:  st_d.ack = own_wr_ack_i[1];
                        MT_GCALL: st_d.ack = gc_data_ack_i;
                        default:  st_d.ack = 1'b0;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_STATE;
        else         st_q <= st_d;
    end

    assign match_o     = st_q.match;
    assign read_o      = st_q.rd;
    assign ack_valid_o = st_q.ack_vld;
    assign ack_o       = st_q.ack;

    // R10
    ack_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_o |-> $past(byte_valid_i));
    // R10
    ack_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> ack_valid_o);
    // R11
    stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (match_o == MT_NONE && !read_o && !ack_valid_o));
    // R8
    gc_read_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_valid_i && !stop_i && !start_i && st_q.phase == PH_ADDR && byte_i == GC_RD)
        |=> (ack_valid_o && !ack_o && match_o == MT_NONE));
    // R3
    own0_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o == MT_OWN0) |-> own_en_i[0]);
    // R3
    own1_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o == MT_OWN1) |-> own_en_i[1]);
    // R7
    gc_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o == MT_GCALL) |-> !read_o);
endmodule

// File: tb/tb_i2c_addr_decoder.sv
module tb_i2c_addr_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic start = 0, stop = 0, bv = 0, lb = 0;
    logic [7:0] bd = 0;
    logic [1:0] en = 0, ten = 0, wa = 0;
    logic [1:0][9:0] ad = 0;
    logic gle = 0, gee = 0, gda = 0;
    logic [1:0] match;
    logic rd, av, ak;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench transfer model
    int m_ph = 0;             // 0 idle 1 addr 2 low 3 write 4 read 5 skip
    int m_match = 0;
    bit m_rd = 0;
    bit [1:0] m_cand = 0, m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_decoder dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
        .byte_valid_i(bv), .byte_i(bd), .loopback_i(lb), .own_en_i(en),
        .own_ten_i(ten), .own_addr_i(ad), .own_wr_ack_i(wa),
        .gc_local_en_i(gle), .gc_ext_en_i(gee), .gc_data_ack_i(gda),
        .match_o(match), .read_o(rd), .ack_valid_o(av), .ack_o(ak));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input bit ev, input bit ea);
        chk(tag, {match, rd, av, ak}, {m_match[1:0], m_rd, ev, ea});
    endtask

    function automatic int pri(input bit [1:0] h);
        return h[0] ? 1 : (h[1] ? 2 : 0);
    endfunction

    task automatic do_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        m_ph = 1; m_match = 0; m_rd = 0; m_cand = 0;
        chk_all("R11 start", 0, 0);
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
        m_ph = 0; m_match = 0; m_rd = 0; m_cand = 0; m_sel = 0;
        chk_all("R11 stop", 0, 0);
    endtask

    task automatic send(input bit [7:0] b);
        bit ev, ea;
        string tag;
        bit [1:0] h;
        ev = 0; ea = 0; tag = "R10 ignored";
        if (m_ph == 1) begin
            ev = 1;
            if (b == 8'h00) begin
                tag = "R7"; ea = lb ? gle : gee;
                m_match = ea ? 3 : 0; m_ph = ea ? 3 : 5;
            end else if (b == 8'h01) begin
                tag = "R8"; m_ph = 5;
            end else if (b[7:3] == 5'b11110) begin
                for (int i = 0; i < 2; i++)
                    h[i] = en[i] & ten[i] & (b[2:1] == ad[i][9:8]);
                if (!b[0]) begin
                    tag = "R5 header"; m_cand = h; m_sel = 0; ea = |h;
                    m_ph = ea ? 2 : 5;
                end else begin
                    tag = "R6"; h = h & m_sel; ea = |h;
                    if (ea) begin m_match = pri(h); m_rd = 1; m_ph = 4; end
                    else m_ph = 5;
                end
            end else begin
                tag = "R2";
                for (int i = 0; i < 2; i++)
                    h[i] = en[i] & ~ten[i] & (b[7:1] == ad[i][6:0]);
                ea = |h;
                if (ea) begin m_match = pri(h); m_rd = b[0]; m_ph = b[0] ? 4 : 3; end
                else m_ph = 5;
            end
        end else if (m_ph == 2) begin
            ev = 1; tag = "R5 low";
            for (int i = 0; i < 2; i++)
                h[i] = m_cand[i] & en[i] & ten[i] & (b == ad[i][7:0]);
            m_cand = 0; ea = |h;
            if (ea) begin m_match = pri(h); m_sel = (m_match == 1) ? 2'b01 : 2'b10; m_ph = 3; end
            else m_ph = 5;
        end else if (m_ph == 3) begin
            ev = 1; tag = "R9";
            ea = (m_match == 1) ? wa[0] : (m_match == 2) ? wa[1] : gda;
        end
        @(negedge clk); bd = b; bv = 1;
        @(negedge clk); bv = 0;
        chk_all(tag, ev, ea);
    endtask

    task automatic set_cfg(input bit [1:0] e, input bit [1:0] t,
                           input bit [9:0] a0, input bit [9:0] a1);
        en = e; ten = t; ad[0] = a0; ad[1] = a1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        chk("R1 reset", {match, rd, av, ak}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset released", {match, rd, av, ak}, 0);

        // R2 / R4: both 7-bit at 0x2A, write acks differ
        set_cfg(2'b11, 2'b00, 10'h02A, 10'h02A); wa = 2'b10;
        do_start(); send({7'h2A, 1'b0}); send(8'h55); do_stop();
        // R3: address 0 disabled, address 1 takes over
        set_cfg(2'b10, 2'b00, 10'h02A, 10'h02A);
        do_start(); send({7'h2A, 1'b1}); send(8'h12); do_stop();
        // R3: wrong mode and no match
        set_cfg(2'b01, 2'b01, 10'h02A, 10'h011);
        do_start(); send({7'h2A, 1'b0}); send(8'h77); do_stop();
        // R5 / R6: 10-bit write then repeated start read
        set_cfg(2'b11, 2'b11, 10'h2C5, 10'h1C5); wa = 2'b01;
        do_start(); send(8'b11110_10_0); send(8'hC5); send(8'h3C);
        do_start(); send(8'b11110_10_1); send(8'h99);
        do_stop();
        // R11: stop drops the 10-bit memory
        do_start(); send(8'b11110_10_1); do_stop();
        // R5 low byte mismatch
        do_start(); send(8'b11110_01_0); send(8'hC6); send(8'h01); do_stop();
        // R7 loopback vs external, R8
        gle = 1; gee = 0; gda = 1;
        lb = 1; do_start(); send(8'h00); send(8'hA5); do_stop();
        lb = 0; do_start(); send(8'h00); do_stop();
        do_start(); send(8'h01); do_stop();
        // R11 priority: stop with start and byte in same cycle
        set_cfg(2'b01, 2'b00, 10'h050, 10'h0);
        do_start();
        @(negedge clk); start = 1; stop = 1; bv = 1; bd = {7'h50, 1'b0};
        @(negedge clk); start = 0; stop = 0; bv = 0;
        m_ph = 0; m_match = 0; m_rd = 0; m_sel = 0;
        chk_all("R11 stop priority", 0, 0);
        send({7'h50, 1'b0});  // R10 no start: ignored
        // R11 start beats byte
        @(negedge clk); start = 1; bv = 1; bd = {7'h50, 1'b0};
        @(negedge clk); start = 0; bv = 0;
        m_ph = 1; m_match = 0; m_rd = 0; m_cand = 0;
        chk_all("R11 start priority", 0, 0);
        send({7'h50, 1'b0}); do_stop();

        // random mix
        for (int it = 0; it < 400; it++) begin
            int mode, idx, nd;
            set_cfg(2'($urandom), 2'($urandom), 10'($urandom), 10'($urandom));
            if ($urandom % 3 == 0) ad[1] = ad[0];
            wa = 2'($urandom); gle = 1'($urandom); gee = 1'($urandom);
            gda = 1'($urandom); lb = 1'($urandom);
            mode = $urandom % 6; idx = $urandom % 2; nd = $urandom % 4;
            do_start();
            case (mode)
                0: send({ad[idx][6:0], 1'($urandom)});
                1: begin send({5'b11110, ad[idx][9:8], 1'b0}); send(ad[idx][7:0]); end
                2: begin
                    send({5'b11110, ad[idx][9:8], 1'b0}); send(ad[idx][7:0]);
                    do_start(); send({5'b11110, ad[idx][9:8], 1'b1});
                end
                3: send(8'h00);
                4: send(8'h01);
                default: send(8'($urandom));
            endcase
            for (int k = 0; k < nd; k++) send(8'($urandom));
            do_stop();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule